// File: doc/BRIEF.md
# Dual-Half Programmable Interval Timer

The block holds two independent 32-bit up-counters, the low half and the high half. Each has its own counter and period register and its own interrupt line. One shared control word holds a 2-bit run-mode field for each half: off, single shot or repeating. A global control word selects the timer arrangement and holds a per-half release bit. When a running half's count equals its period, that half pulses its interrupt. In repeating mode the count then restarts from zero. In single-shot mode the count stops and the half's mode field returns to off.

Software reaches the block through a plain register port. A write takes effect at the clock edge where `reg_wr` is sampled high. A read sampled high on `reg_rd` returns its data with `reg_rvalid` one cycle later. The port accepts an access on every cycle, so there is no back-pressure and no ready signal. Only the dual unchained 32-bit arrangement is built. With the period at all ones in repeating mode, a half is a free-running counter over the whole 32-bit range.

Top module: `dual_half_timer`

## Requirements
- R1: After reset, both counters, both periods, the control word and the global control word read 0, and both interrupt outputs are low.
- R2: Byte offsets: 0x00 identification (reads parameter `ID_VALUE`), 0x10 low counter, 0x14 high counter, 0x18 low period, 0x1C high period, 0x20 control word, 0x24 global control. Offset 0x28 and all other offsets read 0 and ignore writes. Read data appears with `reg_rvalid` in the cycle after `reg_rd`.
- R3: The control word holds the low half's mode in bits 7:6 and the high half's in bits 23:22, where 0 = off, 1 = single shot and 2 = repeating. The value 3 behaves as off.
- R4: A running half adds one to its counter on every clock, starting from the value last written to the counter.
- R5: When a running half's counter equals its period at a clock edge, its interrupt is high for exactly the next clock cycle. Enabling at edge E from start value c with period p gives the pulse in the cycle after edge E+(p−c+1).
- R6: In repeating mode the counter returns to 0 after the match, so later pulses come every p+1 clocks.
- R7: In single-shot mode the counter stays at the period after the match, only one pulse is produced, and the half's mode field reads back 0.
- R8: Global control bit 0 releases the low half and bit 1 releases the high half. While a half's bit is 0, or its mode is off, its counter holds and can still be written.
- R9: Global control bits 3:2 must be 1 (dual unchained) for either half to run. Any other value holds both counters.
- R10: With the period at 0xFFFFFFFF in repeating mode, the counter passes 0xFFFFFFFF and continues from 0.
- R11: A counter write in the same cycle as counting wins. The half then counts on from the written value.
- R12: The halves are independent. Running one never moves the other's counter or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| irq_lo | output | 1 | Low-half match pulse |
| irq_hi | output | 1 | High-half match pulse |

## Verification
The bench counts clocks from the enabling write to the first pulse, and then between pulses. A design that matched one cycle early, or restarted at 1 instead of 0, would show a count that is off by one. Single-shot runs check that the counter parks at the period and the mode field clears. A design that kept going would raise a second pulse or read back a moved count. The bench also drives the rarer cases: a reserved mode value, a cleared release bit, a wrong arrangement value, the all-ones wrap and a counter write during a run. A design that ignored the gating would move a counter that must stay frozen. A design with a broken wrap would never pulse again after 0xFFFFFFFF.

// File: rtl/dht_pkg.sv
package dht_pkg;
  typedef enum logic [1:0] {
    EN_OFF  = 2'd0,
    EN_ONCE = 2'd1,
    EN_LOOP = 2'd2,
    EN_RSVD = 2'd3
  } en_mode_e;

  localparam logic [1:0] GMODE_DUAL32 = 2'd1;
  localparam int NUM_HALVES = 2;
  localparam int LO_SHIFT   = 6;
  localparam int HI_SHIFT   = 22;

  localparam logic [7:0] OFS_ID     = 8'h00;
  localparam logic [7:0] OFS_CNT_LO = 8'h10;
  localparam logic [7:0] OFS_CNT_HI = 8'h14;
  localparam logic [7:0] OFS_PRD_LO = 8'h18;
  localparam logic [7:0] OFS_PRD_HI = 8'h1C;
  localparam logic [7:0] OFS_CTRL   = 8'h20;
  localparam logic [7:0] OFS_GCTRL  = 8'h24;
endpackage

// File: rtl/dht_half.sv
module dht_half
  import dht_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [1:0]       mode,
  input  logic             cnt_wr,
  input  logic             prd_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] prd_q,
  output logic             irq,
  output logic             oneshot_done
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic active, hit;
  assign active       = run_en && (mode == EN_ONCE || mode == EN_LOOP);
  assign hit          = active && !cnt_wr && (cnt_q == prd_q);
  assign oneshot_done = hit && (mode == EN_ONCE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      prd_q <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= hit;
      if (prd_wr) prd_q <= wdata;
      if (cnt_wr)      cnt_q <= wdata;
      else if (hit) begin
        if (mode == EN_LOOP) cnt_q <= '0;
      end else if (active) cnt_q <= cnt_q + ONE;
    end
  end

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cnt_wr && cnt_q != prd_q) |=> cnt_q == $past(cnt_q) + ONE);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cnt_wr) |=> $stable(cnt_q));
  // R6
  loop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == EN_LOOP) |=> (cnt_q == '0 && irq));
  // R7
  once_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == EN_ONCE) |=> (irq && $stable(cnt_q)));
  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && mode == EN_LOOP && $past(mode) == EN_LOOP && prd_q != '0 && !prd_wr) |=> !irq);
endmodule

// File: rtl/dht_regfile.sv
module dht_regfile
  import dht_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h0001_7A11
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr,
  input  logic                              rd,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic [NUM_HALVES-1:0][DATA_W-1:0] cnt_i,
  input  logic [NUM_HALVES-1:0][DATA_W-1:0] prd_i,
  input  logic [NUM_HALVES-1:0]             done_i,
  output logic [NUM_HALVES-1:0]             cnt_wr,
  output logic [NUM_HALVES-1:0]             prd_wr,
  output logic [NUM_HALVES-1:0][1:0]        mode_o,
  output logic [NUM_HALVES-1:0]             run_o,
  output logic [DATA_W-1:0]                 rdata,
  output logic                              rvalid
);
  logic [NUM_HALVES-1:0] rel_q;
  logic [1:0]            gmode_q;
  logic [DATA_W-1:0]     ctrl_word, rd_mux;
  logic                  ctrl_wr;

  assign ctrl_wr = wr && (addr == ADDR_W'(OFS_CTRL));

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    localparam int SH = (h == 0) ? LO_SHIFT : HI_SHIFT;
    localparam logic [7:0] CNT_OFS = (h == 0) ? OFS_CNT_LO : OFS_CNT_HI;
    localparam logic [7:0] PRD_OFS = (h == 0) ? OFS_PRD_LO : OFS_PRD_HI;
    logic [1:0] mode_q;

    assign cnt_wr[h] = wr && (addr == ADDR_W'(CNT_OFS));
    assign prd_wr[h] = wr && (addr == ADDR_W'(PRD_OFS));
    assign mode_o[h] = mode_q;
    assign run_o[h]  = rel_q[h] && (gmode_q == GMODE_DUAL32);

    always_ff @(posedge clk) begin
      if (!rst_n)          mode_q <= EN_OFF;
      else if (ctrl_wr)    mode_q <= wdata[SH+1:SH];
      else if (done_i[h])  mode_q <= EN_OFF;
    end

    // R7
    once_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i[h] && !ctrl_wr) |=> mode_q == EN_OFF);
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[LO_SHIFT+1:LO_SHIFT] = g_half[0].mode_q;
    ctrl_word[HI_SHIFT+1:HI_SHIFT] = g_half[1].mode_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_q   <= '0;
      gmode_q <= 2'd0;
    end else if (wr && addr == ADDR_W'(OFS_GCTRL)) begin
      rel_q   <= wdata[NUM_HALVES-1:0];
      gmode_q <= wdata[3:2];
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(OFS_ID):     rd_mux = DATA_W'(ID_VALUE);
      ADDR_W'(OFS_CNT_LO): rd_mux = cnt_i[0];
      ADDR_W'(OFS_CNT_HI): rd_mux = cnt_i[1];
      ADDR_W'(OFS_PRD_LO): rd_mux = prd_i[0];
      ADDR_W'(OFS_PRD_HI): rd_mux = prd_i[1];
      ADDR_W'(OFS_CTRL):   rd_mux = ctrl_word;
      ADDR_W'(OFS_GCTRL):  rd_mux = DATA_W'({gmode_q, rel_q});
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rd_mux;
    end
  end

  // R2
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(rd));
endmodule

// File: rtl/dual_half_timer.sv
module dual_half_timer
  import dht_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] ID_VALUE = 32'h0001_7A11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int CNT_W = 32;

  logic [NUM_HALVES-1:0][CNT_W-1:0] cnt_v, prd_v;
  logic [NUM_HALVES-1:0]            done_v, cnt_wr_v, prd_wr_v, run_v, irq_v;
  logic [NUM_HALVES-1:0][1:0]       mode_v;

  dht_regfile #(.ADDR_W(ADDR_W), .DATA_W(CNT_W), .ID_VALUE(ID_VALUE)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .cnt_i(cnt_v), .prd_i(prd_v), .done_i(done_v),
    .cnt_wr(cnt_wr_v), .prd_wr(prd_wr_v), .mode_o(mode_v), .run_o(run_v),
    .rdata(reg_rdata), .rvalid(reg_rvalid)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_cnt
    dht_half #(.CNT_W(CNT_W)) half_i (
      .clk(clk), .rst_n(rst_n), .run_en(run_v[h]), .mode(mode_v[h]),
      .cnt_wr(cnt_wr_v[h]), .prd_wr(prd_wr_v[h]), .wdata(reg_wdata),
      .cnt_q(cnt_v[h]), .prd_q(prd_v[h]), .irq(irq_v[h]),
      .oneshot_done(done_v[h])
    );
  end

  assign irq_lo = irq_v[0];
  assign irq_hi = irq_v[1];
endmodule

// File: tb/dual_half_timer_tb.sv
module dual_half_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic reg_rvalid, irq_lo, irq_hi;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_half_timer #(.ADDR_W(8), .ID_VALUE(32'h0001_7A11)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    check("R2 rvalid", 32'(reg_rvalid), 32'd1);
    d = reg_rdata;
  endtask

  task automatic wait_irq(bit hi, int limit, output int k);
    k = 0;
    while (((hi ? irq_hi : irq_lo) == 1'b0) && k < limit) begin
      @(negedge clk); k++;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq_lo", 32'(irq_lo), 0);
    check("R1 irq_hi", 32'(irq_hi), 0);
    rd(8'h10, d); check("R1 cnt_lo", d, 0);
    rd(8'h14, d); check("R1 cnt_hi", d, 0);
    rd(8'h18, d); check("R1 prd_lo", d, 0);
    rd(8'h1C, d); check("R1 prd_hi", d, 0);
    rd(8'h20, d); check("R1 ctrl", d, 0);
    rd(8'h24, d); check("R1 gctrl", d, 0);
    rd(8'h00, d); check("R2 id", d, 32'h0001_7A11);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(8'h18, 32'h1111_0001); wr(8'h1C, 32'h2222_0002);
    wr(8'h10, 32'h3333_0003); wr(8'h14, 32'h4444_0004);
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h18, d); check("R2 prd_lo", d, 32'h1111_0001);
    rd(8'h1C, d); check("R2 prd_hi", d, 32'h2222_0002);
    rd(8'h10, d); check("R2 cnt_lo", d, 32'h3333_0003);
    rd(8'h14, d); check("R2 cnt_hi", d, 32'h4444_0004);
    rd(8'h28, d); check("R2 wdog reads 0", d, 0);
    wr(8'h20, 32'h0080_0040);
    rd(8'h20, d); check("R3 field positions", d, 32'h0080_0040);
    wr(8'h20, 0);
    wr(8'h24, 32'h7);
    rd(8'h24, d); check("R2 gctrl", d, 32'h7);
  endtask

  task automatic t_periodic();
    int k;
    logic [31:0] d;
    wr(8'h10, 10); wr(8'h18, 20);
    wr(8'h20, 2 << 6);
    wait_irq(0, 100, k); check("R5 first pulse delay", k, 11);
    @(negedge clk); check("R5 pulse one cycle", 32'(irq_lo), 0);
    wait_irq(0, 100, k); check("R6 repeat interval", k + 1, 21);
    wr(8'h20, 0);
    rd(8'h10, d); check("R6 restart from zero", d, 1);
    idle(5);
    rd(8'h10, d); check("R8 off holds", d, 1);
  endtask

  task automatic t_oneshot();
    int k;
    logic [31:0] d;
    wr(8'h10, 0); wr(8'h18, 5);
    wr(8'h20, 1 << 6);
    wait_irq(0, 100, k); check("R5 once delay", k, 6);
    @(negedge clk);
    wait_irq(0, 30, k); check("R7 single pulse", k, 30);
    rd(8'h10, d); check("R7 parked at period", d, 5);
    rd(8'h20, d); check("R7 field cleared", d, 0);
  endtask

  task automatic t_high();
    int k;
    logic [31:0] d;
    wr(8'h10, 50); wr(8'h14, 0); wr(8'h1C, 3);
    wr(8'h20, 2 << 22);
    wait_irq(1, 100, k); check("R12 high pulse delay", k, 4);
    check("R12 low irq quiet", 32'(irq_lo), 0);
    wr(8'h20, 0);
    rd(8'h10, d); check("R12 low counter untouched", d, 50);
  endtask

  task automatic t_reserved();
    int k;
    logic [31:0] d;
    wr(8'h10, 0); wr(8'h18, 2);
    wr(8'h20, 3 << 6);
    wait_irq(0, 10, k); check("R3 mode 3 no pulse", k, 10);
    rd(8'h10, d); check("R3 mode 3 holds", d, 0);
    wr(8'h20, 0);
  endtask

  task automatic t_release();
    int k;
    logic [31:0] d;
    wr(8'h24, 32'h6);
    wr(8'h20, 2 << 6);
    wait_irq(0, 10, k); check("R8 held low half no pulse", k, 10);
    rd(8'h10, d); check("R8 held counter", d, 0);
    wr(8'h10, 7);
    rd(8'h10, d); check("R8 write while held", d, 7);
    wr(8'h20, 0);
    wr(8'h24, 32'h7);
  endtask

  task automatic t_gmode();
    logic [31:0] d;
    wr(8'h24, 32'h3);
    wr(8'h10, 9); wr(8'h14, 9);
    wr(8'h20, (2 << 6) | (2 << 22));
    idle(8);
    rd(8'h10, d); check("R9 low frozen", d, 9);
    rd(8'h14, d); check("R9 high frozen", d, 9);
    wr(8'h20, 0);
    wr(8'h24, 32'h7);
  endtask

  task automatic t_wrap();
    int k;
    logic [31:0] d;
    wr(8'h10, 32'hFFFF_FFFD); wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h20, 2 << 6);
    wait_irq(0, 20, k); check("R10 pulse at all ones", k, 3);
    wr(8'h20, 0);
    rd(8'h10, d); check("R10 wraps to zero", d, 1);
  endtask

  task automatic t_write_wins();
    int k;
    wr(8'h10, 0); wr(8'h18, 100);
    wr(8'h20, 2 << 6);
    wr(8'h10, 98);
    wait_irq(0, 200, k); check("R11 count from written value", k, 3);
    wr(8'h20, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_periodic();
    t_oneshot();
    t_high();
    t_reserved();
    t_release();
    t_gmode();
    t_wrap();
    t_write_wins();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule